// File: doc/BRIEF.md
# NAND Controller Interrupt Status Unit

This unit gathers the six event sources of a NAND flash controller into a sticky interrupt status register. A programmable enable mask selects which latched events drive a level-high interrupt line. Events that are not enabled are still recorded. A software read of the sticky register returns its contents and empties it in the same access. An event that lands in the cycle of that read survives the clear, so no event is lost.

A second, side-effect-free register shows the live condition of the controller: the two ready levels, ECC completion, whether errors were found, a two-bit corrected-symbol count and decoder failure. A registered device-ready output is high only while both the flash and the controller report ready. Register access uses a plain read strobe, write strobe and word address. Read data is registered and appears one cycle after the strobe.

Top module: `nand_irq_status`

## Requirements
- R1: After a synchronous reset, the sticky status, the mask, `irq`, `dev_ready` and `rdata` are all zero.
- R2: A high pulse on `evt_in[i]` sets sticky bit i. Bit 0 is write-protect fault, bit 1 ECC ready, bit 2 decode error, bit 3 decode failure, bit 4 controller ready and bit 5 NAND ready. The bit then stays set until the status register is read.
- R3: A read at address 0 returns the sticky bits held before the access in `rdata[5:0]`, with zeros above, on the next cycle. The same read clears every sticky bit.
- R4: An event asserted in the same cycle as a status read is still set after the clear.
- R5: A write at address 1 loads the mask from `wdata[5:0]`. A read at address 1 returns it. `irq` is high, one cycle after the state it reflects, exactly when some sticky bit and its mask bit are both set. Masked-off events are still latched.
- R6: A read at address 2 returns the live vector: bit 0 NAND ready, bit 1 controller ready, bit 2 ECC ready, bit 3 errors detected, bits 5:4 the corrected-symbol count, bit 6 decoder failure, and zeros above. The read changes neither the sticky status nor `irq`.
- R7: `dev_ready` is high one cycle after `nand_rdy` and `ctl_rdy` are both high, and low otherwise.
- R8: Writes to addresses 0, 2 and 3 change no state. A read at address 3 returns zero. `rdata` holds its value when no read is strobed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| addr | input | ADDR_W (2) | Register word address |
| wdata | input | DATA_W (32) | Write data |
| rdata | output | DATA_W (32) | Registered read data |
| evt_in | input | 6 | Event pulses, one per sticky bit |
| nand_rdy | input | 1 | Live flash ready level |
| ctl_rdy | input | 1 | Live controller ready level |
| ecc_rdy | input | 1 | Live ECC complete level |
| err_seen | input | 1 | Live errors-detected flag |
| fix_cnt | input | 2 | Corrected symbols minus one |
| dec_fail | input | 1 | Live decoder failure flag |
| irq | output | 1 | Active-high interrupt |
| dev_ready | output | 1 | Flash and controller both ready |

## Verification
An event pulse sampled at edge k is in the sticky register after edge k. It drives `irq` after edge k+1. It can be seen in `rdata` after the edge that samples a read strobed at edge k+1 or later. `rdata` and `dev_ready` follow their stimulus by one edge. The bench drives every input on the falling edge. It advances a behavioural model on the rising edge, using the pre-edge state, and compares all three outputs on the next falling edge. Each expected value is therefore taken in exactly the cycle the registers deliver it.

// File: rtl/nirq_pkg.sv
package nirq_pkg;
  localparam int NUM_SRC = 6;
  localparam int LIVE_W  = 7;

  typedef enum logic [1:0] {
    SEL_STICKY = 2'd0,
    SEL_ENABLE = 2'd1,
    SEL_LIVE   = 2'd2,
    SEL_VOID   = 2'd3
  } reg_sel_e;

  typedef struct packed {
    logic       dec_fail;
    logic [1:0] fix_cnt;
    logic       err_seen;
    logic       ecc_rdy;
    logic       ctl_rdy;
    logic       nand_rdy;
  } live_t;
endpackage

// File: rtl/nirq_latch.sv
module nirq_latch #(
  parameter int N = 6
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] evt,
  input  logic         clr,
  output logic [N-1:0] stat
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    logic held_q;
    always_ff @(posedge clk) begin
      if (rst) held_q <= 1'b0;
      else     held_q <= (held_q & ~clr) | evt[i];
    end
    assign stat[i] = held_q;

    // R2
    sticky_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (stat[i] && !clr) |=> stat[i]);
    // R4
    race_keep_chk: assert property (@(posedge clk) disable iff (rst)
      (clr && evt[i]) |=> stat[i]);
  end

  // R3
  clear_all_chk: assert property (@(posedge clk) disable iff (rst)
    (clr && evt == '0) |=> (stat == '0));
endmodule

// File: rtl/nirq_mask.sv
module nirq_mask #(
  parameter int N = 6
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         we,
  input  logic [N-1:0] wval,
  output logic [N-1:0] mask
);
  logic [N-1:0] mask_q;
  always_ff @(posedge clk) begin
    if (rst)     mask_q <= '0;
    else if (we) mask_q <= wval;
  end
  assign mask = mask_q;

  // R8
  mask_keep_chk: assert property (@(posedge clk) disable iff (rst)
    !we |=> $stable(mask));
endmodule

// File: rtl/nirq_irq.sv
module nirq_irq #(
  parameter int N = 6
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] stat,
  input  logic [N-1:0] mask,
  output logic         irq
);
  logic irq_q;
  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= |(stat & mask);
  end
  assign irq = irq_q;

  // R5
  irq_rise_chk: assert property (@(posedge clk) disable iff (rst)
    (|(stat & mask)) |=> irq);
  // R5
  irq_low_chk: assert property (@(posedge clk) disable iff (rst)
    !(|(stat & mask)) |=> !irq);
endmodule

// File: rtl/nirq_live.sv
module nirq_live
  import nirq_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       nand_rdy,
  input  logic       ctl_rdy,
  input  logic       ecc_rdy,
  input  logic       err_seen,
  input  logic [1:0] fix_cnt,
  input  logic       dec_fail,
  output live_t      live,
  output logic       dev_ready
);
  logic rdy_q;

  always_comb begin
    live.nand_rdy = nand_rdy;
    live.ctl_rdy  = ctl_rdy;
    live.ecc_rdy  = ecc_rdy;
    live.err_seen = err_seen;
    live.fix_cnt  = fix_cnt;
    live.dec_fail = dec_fail;
  end

  always_ff @(posedge clk) begin
    if (rst) rdy_q <= 1'b0;
    else     rdy_q <= nand_rdy & ctl_rdy;
  end
  assign dev_ready = rdy_q;

  // R7
  ready_both_chk: assert property (@(posedge clk) disable iff (rst)
    dev_ready |-> ($past(nand_rdy) && $past(ctl_rdy)));
endmodule

// File: rtl/nand_irq_status.sv
module nand_irq_status
  import nirq_pkg::*;
#(
  parameter int ADDR_W = 2,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_en,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic [NUM_SRC-1:0] evt_in,
  input  logic              nand_rdy,
  input  logic              ctl_rdy,
  input  logic              ecc_rdy,
  input  logic              err_seen,
  input  logic [1:0]        fix_cnt,
  input  logic              dec_fail,
  output logic              irq,
  output logic              dev_ready
);
  localparam int PAD_S = DATA_W - NUM_SRC;
  localparam int PAD_L = DATA_W - LIVE_W;

  logic [NUM_SRC-1:0] stat, mask;
  live_t              live;
  logic               sel_sticky, sel_enable, sel_live;
  logic               clr, mask_we;
  logic [DATA_W-1:0]  rdata_q, rd_next;
  logic               unused_wdata;

  assign sel_sticky = (addr == ADDR_W'(SEL_STICKY));
  assign sel_enable = (addr == ADDR_W'(SEL_ENABLE));
  assign sel_live   = (addr == ADDR_W'(SEL_LIVE));
  assign clr        = rd_en & sel_sticky;
  assign mask_we    = wr_en & sel_enable;
  assign unused_wdata = ^wdata[DATA_W-1:NUM_SRC];

  nirq_latch #(.N(NUM_SRC)) u_latch (
    .clk(clk), .rst(rst), .evt(evt_in), .clr(clr), .stat(stat));

  nirq_mask #(.N(NUM_SRC)) u_mask (
    .clk(clk), .rst(rst), .we(mask_we), .wval(wdata[NUM_SRC-1:0]),
    .mask(mask));

  nirq_irq #(.N(NUM_SRC)) u_irq (
    .clk(clk), .rst(rst), .stat(stat), .mask(mask), .irq(irq));

  nirq_live u_live (
    .clk(clk), .rst(rst), .nand_rdy(nand_rdy), .ctl_rdy(ctl_rdy),
    .ecc_rdy(ecc_rdy), .err_seen(err_seen), .fix_cnt(fix_cnt),
    .dec_fail(dec_fail), .live(live), .dev_ready(dev_ready));

  always_comb begin
    rd_next = '0;
    if (sel_sticky)      rd_next = {{PAD_S{1'b0}}, stat};
    else if (sel_enable) rd_next = {{PAD_S{1'b0}}, mask};
    else if (sel_live)   rd_next = {{PAD_L{1'b0}}, live};
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata_q <= '0;
    else if (rd_en) rdata_q <= rd_next;
  end
  assign rdata = rdata_q;

  // R6
  live_read_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_en && sel_live && evt_in == '0) |=> $stable(stat));
  // R8
  rdata_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rdata));
  // R8
  void_read_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_en && addr == ADDR_W'(SEL_VOID)) |=> (rdata == '0));
endmodule

// File: tb/nand_irq_status_bench.sv
module nand_irq_status_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        rd_en = 0, wr_en = 0;
  logic [1:0]  addr = 0;
  logic [31:0] wdata = 0;
  logic [31:0] rdata;
  logic [5:0]  evt_in = 0;
  logic        nand_rdy = 0, ctl_rdy = 0, ecc_rdy = 0, err_seen = 0, dec_fail = 0;
  logic [1:0]  fix_cnt = 0;
  logic        irq, dev_ready;

  int tests = 0, fails = 0;
  string tag = "R1";
  bit armed = 0;

  // behavioural reference state
  int m_stat = 0, m_mask = 0, m_rdata = 0;
  bit m_irq = 0, m_rdy = 0;

  always #2 clk = ~clk;

  nand_irq_status u_nand_irq_status (
    .clk(clk), .rst(rst), .rd_en(rd_en), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .evt_in(evt_in), .nand_rdy(nand_rdy),
    .ctl_rdy(ctl_rdy), .ecc_rdy(ecc_rdy), .err_seen(err_seen),
    .fix_cnt(fix_cnt), .dec_fail(dec_fail), .irq(irq), .dev_ready(dev_ready));

  always @(posedge clk) begin
    int live;
    live = int'(nand_rdy) + 2*int'(ctl_rdy) + 4*int'(ecc_rdy)
         + 8*int'(err_seen) + 16*int'(fix_cnt) + 64*int'(dec_fail);
    if (rst) begin
      m_stat = 0; m_mask = 0; m_rdata = 0; m_irq = 0; m_rdy = 0;
    end else begin
      m_irq = (m_stat & m_mask) != 0;
      m_rdy = nand_rdy && ctl_rdy;
      if (rd_en)
        m_rdata = (addr == 0) ? m_stat : (addr == 1) ? m_mask :
                  (addr == 2) ? live : 0;
      m_stat = ((rd_en && addr == 0) ? 0 : m_stat) | int'(evt_in);
      if (wr_en && addr == 1) m_mask = int'(wdata) & 63;
    end
    armed = 1;
  end

  always @(negedge clk) if (armed) begin
    tests++;
    if (rdata !== 32'(m_rdata)) begin
      fails++;
      $display("FAIL %s rdata actual %h expected %h", tag, rdata, m_rdata);
    end
    tests++;
    if (irq !== m_irq) begin
      fails++;
      $display("FAIL %s irq actual %b expected %b", tag, irq, m_irq);
    end
    tests++;
    if (dev_ready !== m_rdy) begin
      fails++;
      $display("FAIL %s dev_ready actual %b expected %b", tag, dev_ready, m_rdy);
    end
  end

  task automatic step(input bit r, input bit w, input int a, input int d, input int e);
    @(negedge clk);
    rd_en = r; wr_en = w; addr = 2'(a); wdata = 32'(d); evt_in = 6'(e);
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) step(0, 0, 0, 0, 0);
  endtask

  task automatic set_live(input int v);
    @(negedge clk);
    {dec_fail, fix_cnt, err_seen, ecc_rdy, ctl_rdy, nand_rdy} = 7'(v);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    tag = "R1"; rst = 0;
    idle(2);
    step(1, 0, 1, 0, 0); idle(1);
    // R2: single pulses are sticky
    tag = "R2";
    step(0, 0, 0, 0, 6'h01); step(0, 0, 0, 0, 6'h08); idle(3);
    // R3: read returns then clears
    tag = "R3";
    step(1, 0, 0, 0, 0); idle(1); step(1, 0, 0, 0, 0); idle(1);
    // R4: event during clearing read survives
    tag = "R4";
    step(0, 0, 0, 0, 6'h04); step(1, 0, 0, 0, 6'h20); idle(1);
    step(1, 0, 0, 0, 0); idle(1);
    // R5: mask, irq, masked latching
    tag = "R5";
    step(0, 1, 1, 32'hFFFF_FF12, 0); step(1, 0, 1, 0, 0); idle(1);
    step(0, 0, 0, 0, 6'h02); idle(3);
    step(1, 0, 0, 0, 0); idle(2);
    step(0, 0, 0, 0, 6'h01); idle(3);
    step(1, 0, 0, 0, 0); idle(2);
    // R6: live layout, no side effect
    tag = "R6";
    step(0, 0, 0, 0, 6'h10); idle(1);
    for (int v = 0; v < 128; v += 9) begin
      set_live(v); step(1, 0, 2, 0, 0); idle(1);
    end
    step(1, 0, 0, 0, 0); idle(2);
    // R7: ready combinations
    tag = "R7";
    for (int v = 0; v < 4; v++) begin set_live(v); idle(2); end
    // R8: ignored writes, void address
    tag = "R8";
    step(0, 0, 0, 0, 6'h08); step(0, 1, 0, 32'hFF, 0); step(0, 1, 2, 32'hFF, 0);
    step(0, 1, 3, 32'hFF, 0); step(1, 0, 3, 0, 0); idle(2);
    step(1, 0, 1, 0, 0); step(1, 0, 0, 0, 0); idle(2);
    // R2: mixed traffic
    tag = "R2";
    begin
      logic [15:0] lf = 16'hACE1;
      for (int k = 0; k < 300; k++) begin
        lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
        set_live(int'(lf[6:0]));
        step(lf[7] & lf[8], lf[9] & lf[10] & lf[11], int'(lf[13:12]),
             int'(lf), (lf[14] ? int'(lf[5:0]) : 0));
      end
    end
    idle(3);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule